// File: doc/BRIEF.md
# Pseudo-Static RAM Refresh Mode Controller

This block is the refresh and mode logic of a pseudo-static RAM whose storage is dynamic but whose pins look like a static RAM. It watches the active-low chip enable, the active-low write strobe and a shared active-low output-enable/refresh pin. From these it decides each cycle whether the device is writing, reading, refreshing one addressed row, refreshing from its own row counter, refreshing itself on a timer, or idle. It drives a one-cycle row-refresh strobe, the row that strobe refers to, the decoded mode and the enable for the data output drivers. The cell array and sensing are outside the block.

The shared pin is interpreted by how long it stays low while chip enable is high. Each new low period fires one refresh of the row held in an 8-bit internal counter, and the counter then advances. If the low period reaches `HOLD_CYC` cycles of the free-running internal clock, a timer takes over and refreshes one counter row every `SELF_INT_CYC` cycles, with no pulses or addresses from outside, until the pin goes high again. A chip-enable-only cycle with the write strobe and the shared pin both high refreshes the row named by the low address bits and leaves the counter alone.

All pins are taken as already synchronous to `clk`. Every output is registered: a pin pattern seen at one rising edge shows on the outputs right after that edge.

Top module: `psram_refresh_ctrl`

## Requirements
- R1: With chip enable low the mode output gives 1 (write) when the write strobe is low, 2 (read) when the write strobe is high and the shared pin is low, and 3 (row refresh by address) when both are high; the mode is registered at the edge that samples the pins.
- R2: With chip enable high the mode output gives 0 (standby) when the shared pin is high and 4 (counter refresh) when it is low and self refresh has not begun.
- R3: A falling chip enable with the write strobe and the shared pin high gives exactly one strobe cycle whose row equals address bits 7..0; address bits 14..8 have no effect on it.
- R4: Entering the chip-enable-high/shared-pin-low state gives exactly one strobe at once, carrying the current counter row, and the counter then advances by one.
- R5: The row counter wraps from 255 to 0.
- R6: Reads, writes and address-driven row refreshes leave the row counter unchanged.
- R7: A low period of fewer than `HOLD_CYC` sampled cycles stays in mode 4; at the `HOLD_CYC`-th low sample the mode becomes 5 (self refresh).
- R8: In self refresh a strobe occurs every `SELF_INT_CYC` cycles, the first `SELF_INT_CYC` cycles after mode 5 appears, each carrying the next counter row with no row repeated from the opening strobe.
- R9: Self refresh ends on the first sample with the shared pin high or chip enable low.
- R10: The data output enable is high only in the cycle after a read pattern was sampled, and low in every refresh mode and standby.
- R11: While reset is asserted the mode is 0, the strobe and output enable are low, and the counter returns to row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| oe_rfsh_n | input | 1 | Output enable / refresh request, active low |
| addr | input | 15 | Address; bits 7..0 are the row |
| row_strobe | output | 1 | One-cycle refresh of `row_addr` |
| row_addr | output | 8 | Row selected: counter when chip enable is high, address otherwise |
| mode | output | 3 | Decoded mode code (0..5) |
| dout_en | output | 1 | Data output drive enable |

## Verification
The assertions assume the pins are synchronous to `clk` and that the two timing parameters are at least 2, so that the low-time counter and the row timer each have a distinct terminal value. The self-refresh spacing property also assumes that a self-refresh period, once begun, is not broken by a one-cycle chip-enable pulse between strobes; the bench changes pins only on falling clock edges, enters self refresh from a clean standby state and leaves it by raising the shared pin alone, so every sequence it drives stays inside those assumptions.

// File: rtl/psram_refresh_pkg.sv
package psram_refresh_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE  = 3'd0,
    MODE_WR    = 3'd1,
    MODE_RD    = 3'd2,
    MODE_CEREF = 3'd3,
    MODE_AUTO  = 3'd4,
    MODE_SELF  = 3'd5
  } psram_mode_e;

  // Pin pattern to mode, before the self-refresh override.
  function automatic psram_mode_e pins_to_mode(input logic ce_n,
                                               input logic wr_n,
                                               input logic oe_n);
    psram_mode_e m;
    if (ce_n) begin
      m = oe_n ? MODE_IDLE : MODE_AUTO;
    end else if (!wr_n) begin
      m = MODE_WR;
    end else begin
      m = oe_n ? MODE_CEREF : MODE_RD;
    end
    return m;
  endfunction

  // True for modes in which a row strobe is legal.
  function automatic logic is_refresh_mode(input psram_mode_e m);
    return (m == MODE_CEREF) || (m == MODE_AUTO) || (m == MODE_SELF);
  endfunction

endpackage

// File: rtl/psram_pin_decode.sv
module psram_pin_decode
  import psram_refresh_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ce_n,
  input  logic        wr_n,
  input  logic        oe_n,
  output psram_mode_e pin_mode,
  output logic        refresh_low,
  output logic        refresh_begin,
  output logic        ceref_begin
);

  logic ce_n_q;
  logic refresh_low_q;

  assign pin_mode      = pins_to_mode(ce_n, wr_n, oe_n);
  assign refresh_low   = ce_n & ~oe_n;
  assign refresh_begin = refresh_low & ~refresh_low_q;
  assign ceref_begin   = ~ce_n & ce_n_q & wr_n & oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n_q        <= 1'b1;
      refresh_low_q <= 1'b0;
    end else begin
      ce_n_q        <= ce_n;
      refresh_low_q <= refresh_low;
    end
  end

endmodule

// File: rtl/psram_hold_timer.sv
module psram_hold_timer #(
  parameter int HOLD_CYC     = 16,
  parameter int SELF_INT_CYC = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic refresh_low,
  output logic self_nxt,
  output logic self_enter,
  output logic self_tick
);

  localparam int LOW_W = $clog2(HOLD_CYC + 1);
  localparam int TMR_W = $clog2(SELF_INT_CYC);
  localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(HOLD_CYC - 1);
  localparam logic [LOW_W-1:0] LOW_SAT  = LOW_W'(HOLD_CYC);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(SELF_INT_CYC - 1);

  logic [LOW_W-1:0] low_cnt_q;
  logic [TMR_W-1:0] tmr_q;
  logic             self_q;

  function automatic logic [LOW_W-1:0] sat_inc(input logic [LOW_W-1:0] v);
    return (v == LOW_SAT) ? v : v + 1'b1;
  endfunction

  function automatic logic [TMR_W-1:0] wrap_inc(input logic [TMR_W-1:0] v);
    return (v == TMR_LAST) ? '0 : v + 1'b1;
  endfunction

  assign self_enter = refresh_low & ~self_q & (low_cnt_q == LOW_LAST);
  assign self_nxt   = refresh_low & (self_q | self_enter);
  assign self_tick  = refresh_low & self_q & (tmr_q == TMR_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt_q <= '0;
      tmr_q     <= '0;
      self_q    <= 1'b0;
    end else begin
      low_cnt_q <= refresh_low ? sat_inc(low_cnt_q) : '0;
      self_q    <= self_nxt;
      if (!self_nxt || self_enter) begin
        tmr_q <= '0;
      end else begin
        tmr_q <= wrap_inc(tmr_q);
      end
    end
  end

endmodule

// File: rtl/psram_row_counter.sv
module psram_row_counter #(
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [ROW_W-1:0] row_cnt
);

  function automatic logic [ROW_W-1:0] next_row(input logic [ROW_W-1:0] r);
    return r + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_cnt <= '0;
    end else if (step) begin
      row_cnt <= next_row(row_cnt);
    end
  end

endmodule

// File: rtl/psram_refresh_ctrl.sv
module psram_refresh_ctrl
  import psram_refresh_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int ROW_W        = 8,
  parameter int HOLD_CYC     = 16,
  parameter int SELF_INT_CYC = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              wr_n,
  input  logic              oe_rfsh_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              row_strobe,
  output logic [ROW_W-1:0]  row_addr,
  output logic [2:0]        mode,
  output logic              dout_en
);

  psram_mode_e      pin_mode;
  psram_mode_e      mode_nxt;
  logic             refresh_low;
  logic             refresh_begin;
  logic             ceref_begin;
  logic             self_nxt;
  logic             self_enter;
  logic             self_tick;
  logic             cnt_step;
  logic [ROW_W-1:0] row_cnt;

  psram_pin_decode u_dec (
    .clk           (clk),
    .rst_n         (rst_n),
    .ce_n          (ce_n),
    .wr_n          (wr_n),
    .oe_n          (oe_rfsh_n),
    .pin_mode      (pin_mode),
    .refresh_low   (refresh_low),
    .refresh_begin (refresh_begin),
    .ceref_begin   (ceref_begin)
  );

  psram_hold_timer #(
    .HOLD_CYC     (HOLD_CYC),
    .SELF_INT_CYC (SELF_INT_CYC)
  ) u_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .refresh_low (refresh_low),
    .self_nxt    (self_nxt),
    .self_enter  (self_enter),
    .self_tick   (self_tick)
  );

  assign cnt_step = refresh_begin | self_tick;

  psram_row_counter #(.ROW_W(ROW_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (cnt_step),
    .row_cnt (row_cnt)
  );

  assign mode_nxt = self_nxt ? MODE_SELF : pin_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_strobe <= 1'b0;
      row_addr   <= '0;
      mode       <= MODE_IDLE;
      dout_en    <= 1'b0;
    end else begin
      row_strobe <= cnt_step | ceref_begin;
      row_addr   <= ce_n ? row_cnt : addr[ROW_W-1:0];
      mode       <= mode_nxt;
      dout_en    <= (mode_nxt == MODE_RD);
    end
  end

endmodule

// File: rtl/psram_refresh_chk.sv
module psram_refresh_chk
  import psram_refresh_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int ROW_W        = 8,
  parameter int SELF_INT_CYC = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              wr_n,
  input logic              oe_rfsh_n,
  input logic [ADDR_W-1:0] addr,
  input logic              row_strobe,
  input logic [ROW_W-1:0]  row_addr,
  input logic [2:0]        mode,
  input logic              dout_en,
  input logic              cnt_step,
  input logic [ROW_W-1:0]  row_cnt
);

  logic [31:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= '0;
    end else if (mode != 3'(MODE_SELF)) begin
      gap <= '0;
    end else if (row_strobe) begin
      gap <= 32'd1;
    end else begin
      gap <= gap + 32'd1;
    end
  end

  AST_DOUT_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> $past(!ce_n && wr_n && !oe_rfsh_n)); // R10

  AST_CE_ROW_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (row_strobe && mode == 3'(MODE_CEREF)) |-> (row_addr == $past(addr[ROW_W-1:0]))); // R3

  AST_STROBE_IN_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    row_strobe |-> (mode == 3'(MODE_CEREF) || mode == 3'(MODE_AUTO) || mode == 3'(MODE_SELF))); // R4

  AST_COUNTER_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_step |=> (row_cnt == ROW_W'($past(row_cnt) + 1'b1))); // R5

  AST_COUNTER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_step |=> $stable(row_cnt)); // R6

  AST_SELF_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'(MODE_SELF)) |-> $past(ce_n && !oe_rfsh_n)); // R9

  AST_SELF_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (row_strobe && mode == 3'(MODE_SELF)) |-> (gap == 32'(SELF_INT_CYC))); // R8

  AST_DOUT_OFF_IN_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 3'(MODE_RD)) |-> !dout_en); // R10

endmodule

bind psram_refresh_ctrl psram_refresh_chk #(
  .ADDR_W       (ADDR_W),
  .ROW_W        (ROW_W),
  .SELF_INT_CYC (SELF_INT_CYC)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce_n       (ce_n),
  .wr_n       (wr_n),
  .oe_rfsh_n  (oe_rfsh_n),
  .addr       (addr),
  .row_strobe (row_strobe),
  .row_addr   (row_addr),
  .mode       (mode),
  .dout_en    (dout_en),
  .cnt_step   (cnt_step),
  .row_cnt    (row_cnt)
);

// File: tb/test_psram_refresh_ctrl.sv
module test_psram_refresh_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 16;
  localparam int SINT       = 15;
  localparam int SELF_ROWS  = 260;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1;
  logic        wr_n = 1'b1;
  logic        oe_rfsh_n = 1'b1;
  logic [14:0] addr = '0;
  logic        row_strobe;
  logic [7:0]  row_addr;
  logic [2:0]  mode;
  logic        dout_en;

  int          n_checks = 0;
  int          n_fail = 0;
  logic [7:0]  exp_cnt = 8'd0;
  logic [7:0]  exp_q[$];
  string       exp_tag[$];
  bit          mon_on = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  psram_refresh_ctrl #(
    .HOLD_CYC     (HOLD),
    .SELF_INT_CYC (SINT)
  ) i_psram_refresh_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_n       (ce_n),
    .wr_n       (wr_n),
    .oe_rfsh_n  (oe_rfsh_n),
    .addr       (addr),
    .row_strobe (row_strobe),
    .row_addr   (row_addr),
    .mode       (mode),
    .dout_en    (dout_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pins(input logic c, input logic w, input logic o, input logic [14:0] a);
    ce_n = c; wr_n = w; oe_rfsh_n = o; addr = a;
  endtask

  task automatic expect_row(input logic [7:0] r, input string tag);
    exp_q.push_back(r);
    exp_tag.push_back(tag);
  endtask

  // Monitor: every strobe pops the oldest expected row.
  always @(negedge clk) begin
    if (mon_on && row_strobe) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3/R4 unexpected strobe", int'(row_addr), -1);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = exp_tag.pop_front();
        check(row_addr == e, t, int'(row_addr), int'(e));
      end
    end
  end

  // One short counter-refresh pulse of len low cycles.
  task automatic auto_pulse(input int len);
    pins(1'b1, 1'b1, 1'b0, 15'h0);
    expect_row(exp_cnt, "R4 counter row");
    exp_cnt = exp_cnt + 8'd1;
    for (int i = 0; i < len; i++) tick();
    pins(1'b1, 1'b1, 1'b1, 15'h0);
    tick();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    tick(); tick();
    // R11 reset state
    check(mode == 3'd0, "R11 mode in reset", int'(mode), 0);
    check(!row_strobe && !dout_en, "R11 strobe/dout in reset", int'({row_strobe, dout_en}), 0);
    rst_n = 1'b1;
    mon_on = 1'b1;
    tick();
    check(mode == 3'd0, "R2 standby", int'(mode), 0);
    check(row_addr == 8'd0, "R11 counter zero", int'(row_addr), 0);

    // R1 write
    pins(1'b0, 1'b0, 1'b1, 15'h1234); tick();
    check(mode == 3'd1, "R1 write mode", int'(mode), 1);
    check(!dout_en, "R10 dout off in write", int'(dout_en), 0);
    pins(1'b1, 1'b1, 1'b1, 15'h0); tick();

    // R1 read
    pins(1'b0, 1'b1, 1'b0, 15'h0042); tick();
    check(mode == 3'd2, "R1 read mode", int'(mode), 2);
    check(dout_en, "R10 dout on in read", int'(dout_en), 1);
    tick();
    pins(1'b1, 1'b1, 1'b1, 15'h0); tick();
    check(!dout_en, "R10 dout off in standby", int'(dout_en), 0);

    // R3 address-driven refresh, upper bits varied
    pins(1'b0, 1'b1, 1'b1, 15'h7F5A);
    expect_row(8'h5A, "R3 address row");
    tick();
    check(mode == 3'd3, "R1 CE-only refresh mode", int'(mode), 3);
    check(!dout_en, "R10 dout off in CE refresh", int'(dout_en), 0);
    tick(); tick();
    pins(1'b1, 1'b1, 1'b1, 15'h0); tick();
    pins(1'b0, 1'b1, 1'b1, 15'h005A);
    expect_row(8'h5A, "R3 upper bits ignored");
    tick();
    pins(1'b1, 1'b1, 1'b1, 15'h0); tick();
    check(row_addr == exp_cnt, "R6 counter after accesses", int'(row_addr), int'(exp_cnt));

    // R4 counter refresh pulses; R2 mode 4
    pins(1'b1, 1'b1, 1'b0, 15'h0);
    expect_row(exp_cnt, "R4 first counter row");
    exp_cnt = exp_cnt + 8'd1;
    tick();
    check(mode == 3'd4, "R2 counter refresh mode", int'(mode), 4);
    check(!dout_en, "R10 dout off in counter refresh", int'(dout_en), 0);
    tick(); tick();
    pins(1'b1, 1'b1, 1'b1, 15'h0); tick();
    auto_pulse(1);
    auto_pulse(3);

    // R6 CE-only refresh and a write between pulses keep the counter
    pins(1'b0, 1'b1, 1'b1, 15'h00C3);
    expect_row(8'hC3, "R3 row between pulses");
    tick();
    pins(1'b0, 1'b0, 1'b1, 15'h00C3); tick();
    pins(1'b1, 1'b1, 1'b1, 15'h0); tick();
    auto_pulse(2);

    // R7 low time one short of the threshold stays counter refresh
    pins(1'b1, 1'b1, 1'b0, 15'h0);
    expect_row(exp_cnt, "R7 long auto pulse row");
    exp_cnt = exp_cnt + 8'd1;
    for (int i = 1; i < HOLD; i++) tick();
    check(mode == 3'd4, "R7 below threshold", int'(mode), 4);
    pins(1'b1, 1'b1, 1'b1, 15'h0); tick();
    check(mode == 3'd0, "R7 back to standby", int'(mode), 0);

    // R5 run the counter across the wrap
    while (exp_cnt != 8'd254) auto_pulse(1);
    auto_pulse(1);
    auto_pulse(1);
    check(exp_cnt == 8'd0, "R5 model wrapped", int'(exp_cnt), 0);
    auto_pulse(1);

    // R8 self refresh
    pins(1'b1, 1'b1, 1'b0, 15'h0);
    expect_row(exp_cnt, "R8 opening row");
    exp_cnt = exp_cnt + 8'd1;
    for (int k = 0; k < SELF_ROWS; k++) begin
      expect_row(exp_cnt, "R8 self row");
      exp_cnt = exp_cnt + 8'd1;
    end
    for (int i = 1; i <= HOLD + SINT * SELF_ROWS; i++) begin
      tick();
      if (i == HOLD - 1) check(mode == 3'd4, "R7 before threshold", int'(mode), 4);
      if (i == HOLD) check(mode == 3'd5, "R7 self entry", int'(mode), 5);
      if (i == HOLD + SINT - 1) check(!row_strobe, "R8 no early strobe", int'(row_strobe), 0);
      if (i == HOLD + SINT) check(row_strobe, "R8 first self strobe", int'(row_strobe), 1);
    end
    pins(1'b1, 1'b1, 1'b1, 15'h0); tick();
    check(mode == 3'd0, "R9 self exit", int'(mode), 0);
    check(!row_strobe, "R9 no strobe after exit", int'(row_strobe), 0);
    for (int i = 0; i < SINT + 2; i++) tick();
    check(row_addr == exp_cnt, "R8 counter after self", int'(row_addr), int'(exp_cnt));
    auto_pulse(1);
    tick(); tick();
    check(exp_q.size() == 0, "R8 all rows seen", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule